// File: doc/BRIEF.md
# XTEA Half-Round Step Unit

This block is a single-cycle coprocessor datapath that a host CPU drives with register-register custom instructions to speed up XTEA encryption and decryption. Each instruction carries two 32-bit source operands, a 3-bit function select and a 7-bit immediate that must be zero. Each instruction performs one half-round on one 32-bit half of the data block and returns the new value of that half.

Between instructions the unit keeps a hidden running-sum register. An init operation loads the sum. The encrypt-low step advances the sum by the round constant 0x9E3779B9, and the decrypt-high step pulls it back by the same constant. Software therefore issues the steps in strict pairs:

- Encryption: encrypt-low, then encrypt-high.
- Decryption: decrypt-high, then decrypt-low, starting from a sum of constant × rounds.

The 128-bit key sits in four 32-bit words that the host writes and reads through a small control-register port. Round looping and data buffering stay in software.

The control flow is a two-state machine:

- `ST_IDLE` moves to `ST_RESP` when `start` is high.
- `ST_RESP` raises `done` for that cycle. It stays in `ST_RESP` on another `start` and returns to `ST_IDLE` otherwise.

Top module: `xtea_step_unit`

## Requirements
- R1: After reset, `done`, `illegal` and `result` are 0, every key word reads 0 and the running sum is 0.
- R2: `funct3`=100 (init) loads the running sum from `rs1`, ignores `rs2` and returns 0.
- R3: `funct3`=000 (encrypt low) returns `rs1` + (M(`rs2`) ^ (sum + key[sum bits 1:0])), where M(x) = ((x<<4) ^ (x>>5)) + x with logical shifts. It then advances the sum by 0x9E3779B9.
- R4: `funct3`=001 (encrypt high) returns `rs2` + (M(`rs1`) ^ (sum + key[sum bits 12:11])), using the already advanced sum. It leaves the sum unchanged.
- R5: `funct3`=011 (decrypt high) returns `rs2` − (M(`rs1`) ^ (sum + key[sum bits 12:11])). It then reduces the sum by 0x9E3779B9.
- R6: `funct3`=010 (decrypt low) returns `rs1` − (M(`rs2`) ^ (sum + key[sum bits 1:0])), using the already reduced sum. It leaves the sum unchanged.
- R7: A write with `key_we` high stores `key_wdata` into key word `key_addr` (0 to 3) at the clock edge. `key_rdata` shows word `key_addr` combinationally.
- R8: Any of the following is illegal: `funct3` of 101, 110 or 111, or a nonzero `funct7`. An illegal operation asserts `illegal` together with `done`, returns 0 and leaves the sum unchanged.
- R9: `done` rises in the cycle after `start` is sampled. For an isolated start it stays high for exactly one cycle.
- R10: All arithmetic wraps modulo 2^32. Twenty encrypt step pairs from sum 0 match a 20-round XTEA encryption. Twenty decrypt step pairs from sum 20×0x9E3779B9 return the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue strobe for one operation |
| funct3 | input | 3 | Operation select |
| funct7 | input | 7 | Immediate field; must be zero |
| rs1 | input | 32 | First source operand (low half v0, or init sum) |
| rs2 | input | 32 | Second source operand (high half v1) |
| result | output | 32 | Registered operation result |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal-operation flag, valid with `done` |
| key_we | input | 1 | Key word write enable |
| key_addr | input | 2 | Key word index |
| key_wdata | input | 32 | Key word write data |
| key_rdata | output | 32 | Key word read data |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, four key words, shifts of 4 and 5, and the high key index taken from sum bits 12:11. At this width the bench's own 32-bit model is exact, including the wraparound. Starting the sum at 20 times the constant drives it through many wraps, so every combination of the low and high key-index bits is reached. Init with nonzero sums reaches arbitrary key-index pairs directly. Those sums also let the bench show, through the encrypt-high result alone, whether an illegal operation or a second encrypt-high step disturbed the hidden sum.

// File: rtl/xtea_pkg.sv
package xtea_pkg;
    localparam int XTEA_W      = 32;
    localparam int XTEA_SHL    = 4;
    localparam int XTEA_SHR    = 5;
    localparam int XTEA_KWORDS = 4;
    localparam int XTEA_KHI    = 11;
    localparam logic [31:0] XTEA_DELTA = 32'h9E37_79B9;

    typedef enum logic [2:0] {
        OP_ENC_LO = 3'b000,
        OP_ENC_HI = 3'b001,
        OP_DEC_LO = 3'b010,
        OP_DEC_HI = 3'b011,
        OP_INIT   = 3'b100
    } xtea_op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xtea_state_e;
endpackage

// File: rtl/xtea_key_bank.sv
module xtea_key_bank #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [NWORDS-1:0][WORD_W-1:0] words
);
    logic [NWORDS-1:0][WORD_W-1:0] bank_q;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                bank_q[g] <= wr_data;
            end
        end
    end

    assign words = bank_q;

    // R7: a write lands in the addressed word
    a_r7_key_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> words[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/xtea_mixer.sv
module xtea_mixer #(
    parameter int WORD_W = 32,
    parameter int SHL    = 4,
    parameter int SHR    = 5
) (
    input  logic [WORD_W-1:0] data,
    input  logic [WORD_W-1:0] sum,
    input  logic [WORD_W-1:0] key_word,
    output logic [WORD_W-1:0] term
);
    logic [WORD_W-1:0] feistel;

    always_comb begin
        feistel = ((data << SHL) ^ (data >> SHR)) + data;
        term    = feistel ^ (sum + key_word);
    end
endmodule

// File: rtl/xtea_step_unit.sv
module xtea_step_unit
    import xtea_pkg::*;
#(
    parameter int          WORD_W = XTEA_W,
    parameter int          KWORDS = XTEA_KWORDS,
    parameter int          SHL    = XTEA_SHL,
    parameter int          SHR    = XTEA_SHR,
    parameter int          KHI    = XTEA_KHI,
    parameter logic [31:0] DELTA  = XTEA_DELTA,
    localparam int         KIDX_W = $clog2(KWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        funct3,
    input  logic [6:0]        funct7,
    input  logic [WORD_W-1:0] rs1,
    input  logic [WORD_W-1:0] rs2,
    output logic [WORD_W-1:0] result,
    output logic              done,
    output logic              illegal,
    input  logic              key_we,
    input  logic [KIDX_W-1:0] key_addr,
    input  logic [WORD_W-1:0] key_wdata,
    output logic [WORD_W-1:0] key_rdata
);
    localparam logic [WORD_W-1:0] DELTA_W = WORD_W'(DELTA);

    xtea_state_e                    state_q, state_d;
    logic [WORD_W-1:0]              sum_q;
    logic [WORD_W-1:0]              result_q, result_d;
    logic                           illegal_q;
    logic                           legal;
    logic [KWORDS-1:0][WORD_W-1:0]  key_words;
    logic [1:0][WORD_W-1:0]         lane_term;

    xtea_key_bank #(.WORD_W(WORD_W), .NWORDS(KWORDS)) u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (key_we),
        .wr_idx  (key_addr),
        .wr_data (key_wdata),
        .words   (key_words)
    );

    assign key_rdata = key_words[key_addr];

    // lane 0 mixes rs2 with the low-index key; lane 1 mixes rs1 with the high-index key
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [WORD_W-1:0] lane_data;
        logic [KIDX_W-1:0] lane_idx;
        if (g == 0) begin : g_lo
            assign lane_data = rs2;
            assign lane_idx  = sum_q[KIDX_W-1:0];
        end else begin : g_hi
            assign lane_data = rs1;
            assign lane_idx  = sum_q[KHI +: KIDX_W];
        end
        xtea_mixer #(.WORD_W(WORD_W), .SHL(SHL), .SHR(SHR)) u_mix (
            .data     (lane_data),
            .sum      (sum_q),
            .key_word (key_words[lane_idx]),
            .term     (lane_term[g])
        );
    end

    always_comb begin
        legal = (funct7 == 7'd0);
        unique case (funct3)
            OP_ENC_LO, OP_ENC_HI, OP_DEC_LO, OP_DEC_HI, OP_INIT: ;
            default: legal = 1'b0;
        endcase
    end

    always_comb begin
        result_d = '0;
        if (legal) begin
            unique case (funct3)
                OP_ENC_LO: result_d = rs1 + lane_term[0];
                OP_ENC_HI: result_d = rs2 + lane_term[1];
                OP_DEC_LO: result_d = rs1 - lane_term[0];
                OP_DEC_HI: result_d = rs2 - lane_term[1];
                default:   result_d = '0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = start ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and running sum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q  <= '0;
            illegal_q <= 1'b0;
            sum_q     <= '0;
        end else if (start) begin
            result_q  <= result_d;
            illegal_q <= !legal;
            if (legal) begin
                unique case (funct3)
                    OP_INIT:   sum_q <= rs1;
                    OP_ENC_LO: sum_q <= sum_q + DELTA_W;
                    OP_DEC_HI: sum_q <= sum_q - DELTA_W;
                    default:   sum_q <= sum_q;
                endcase
            end
        end
    end

    assign result  = result_q;
    assign illegal = illegal_q && (state_q == ST_RESP);
    assign done    = (state_q == ST_RESP);

    // R9: completion follows the start by one cycle
    a_r9_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R9: no completion without a start one cycle earlier
    a_r9_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    // R8: the illegal flag only accompanies a completion
    a_r8_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);
    // R8: an illegal operation returns zero
    a_r8_illegal_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));
    // R8: an illegal operation leaves the sum alone
    a_r8_illegal_keeps_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !legal) |=> $stable(sum_q));
    // R4: encrypt-high leaves the sum alone
    a_r4_enc_hi_keeps_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (start && funct7 == 7'd0 && funct3 == OP_ENC_HI) |=> $stable(sum_q));
endmodule

// File: tb/test_xtea_step_unit.sv
module test_xtea_step_unit;
    localparam logic [31:0] DELTA = 32'h9E37_79B9;
    localparam int ROUNDS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  funct3 = '0;
    logic [6:0]  funct7 = '0;
    logic [31:0] rs1 = '0, rs2 = '0;
    logic [31:0] result;
    logic        done, illegal;
    logic        key_we = 1'b0;
    logic [1:0]  key_addr = '0;
    logic [31:0] key_wdata = '0;
    logic [31:0] key_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] mkey [4] = '{32'h0, 32'h0, 32'h0, 32'h0};

    always #10 clk = ~clk;

    xtea_step_unit i_xtea_step_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .funct3(funct3), .funct7(funct7),
        .rs1(rs1), .rs2(rs2), .result(result), .done(done), .illegal(illegal),
        .key_we(key_we), .key_addr(key_addr), .key_wdata(key_wdata), .key_rdata(key_rdata)
    );

    function automatic logic [31:0] fmix(input logic [31:0] x);
        return ((x << 4) ^ (x >> 5)) + x;
    endfunction

    function automatic logic [31:0] tlo(input logic [31:0] v1, input logic [31:0] s);
        return fmix(v1) ^ (s + mkey[s[1:0]]);
    endfunction

    function automatic logic [31:0] thi(input logic [31:0] v0, input logic [31:0] s);
        return fmix(v0) ^ (s + mkey[s[12:11]]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [6:0] f7, input logic [2:0] f3,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic d, output logic il);
        @(negedge clk);
        start = 1'b1; funct7 = f7; funct3 = f3; rs1 = a; rs2 = b;
        @(negedge clk);
        start = 1'b0;
        r = result; d = done; il = illegal;
    endtask

    task automatic op(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b,
                      output logic [31:0] r);
        logic d, il;
        issue(7'd0, f3, a, b, r, d, il);
        chk("R9 done", 32'(d), 32'd1);
        chk("R8 legal op flag", 32'(il), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R1 done", 32'(done), 0);
        chk("R1 illegal", 32'(illegal), 0);
        chk("R1 result", result, 0);
        for (int i = 0; i < 4; i++) begin
            key_addr = 2'(i); #1;
            chk("R1 key word", key_rdata, 0);
        end
        // sum 0, keys 0: encrypt-high reveals the sum
        op(3'b001, 32'h1, 32'h5, r);
        chk("R1 sum zero", r, 32'h5 + thi(32'h1, 32'h0));
    endtask

    task automatic t_keys();
        logic [31:0] kv [4] = '{32'h207230BA, 32'h1FFBA710, 32'hC45271EF, 32'hDD01768A};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            key_we = 1'b1; key_addr = 2'(i); key_wdata = kv[i];
            mkey[i] = kv[i];
        end
        @(negedge clk);
        key_we = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            key_addr = 2'(i); #1;
            chk("R7 key readback", key_rdata, kv[i]);
        end
    endtask

    task automatic t_init();
        logic [31:0] r;
        logic [31:0] s = 32'h0000_1803;
        op(3'b100, s, 32'hFFFF_FFFF, r);
        chk("R2 init result", r, 0);
        op(3'b001, 32'hA5A5_0001, 32'h1234_5678, r);
        chk("R2 sum from rs1", r, 32'h1234_5678 + thi(32'hA5A5_0001, s));
        // second encrypt-high must see the same sum
        op(3'b001, 32'h0BAD_F00D, 32'h0, r);
        chk("R4 sum unchanged", r, thi(32'h0BAD_F00D, s));
    endtask

    task automatic t_steps();
        logic [31:0] r;
        logic [31:0] s = 32'hFFFF_F802;
        logic [31:0] v0 = 32'hDEAD_BEEF, v1 = 32'h0123_4567;
        op(3'b100, s, 32'h0, r);
        op(3'b000, v0, v1, r);
        chk("R3 enc low", r, v0 + tlo(v1, s));
        s = s + DELTA;
        op(3'b001, v0, v1, r);
        chk("R4 enc high advanced sum", r, v1 + thi(v0, s));
        op(3'b011, v0, v1, r);
        chk("R5 dec high", r, v1 - thi(v0, s));
        s = s - DELTA;
        op(3'b010, v0, v1, r);
        chk("R6 dec low reduced sum", r, v0 - tlo(v1, s));
    endtask

    task automatic t_illegal();
        logic [31:0] r;
        logic d, il;
        logic [31:0] s = 32'h0000_0801;
        logic [2:0] bad [3] = '{3'b101, 3'b110, 3'b111};
        op(3'b100, s, 32'h0, r);
        foreach (bad[i]) begin
            issue(7'd0, bad[i], 32'h1111_1111, 32'h2222_2222, r, d, il);
            chk("R8 illegal flag", 32'(il), 1);
            chk("R8 illegal done", 32'(d), 1);
            chk("R8 illegal result", r, 0);
        end
        issue(7'h20, 3'b000, 32'h1111_1111, 32'h2222_2222, r, d, il);
        chk("R8 funct7 illegal", 32'(il), 1);
        chk("R8 funct7 result", r, 0);
        op(3'b001, 32'h3333_3333, 32'h4444_4444, r);
        chk("R8 sum unchanged", r, 32'h4444_4444 + thi(32'h3333_3333, s));
    endtask

    task automatic t_timing();
        @(negedge clk);
        start = 1'b1; funct7 = 0; funct3 = 3'b001; rs1 = 0; rs2 = 0;
        #1 chk("R9 no done same cycle", 32'(done), 0);
        @(negedge clk);
        start = 1'b0;
        chk("R9 done next cycle", 32'(done), 1);
        @(negedge clk);
        chk("R9 done one cycle only", 32'(done), 0);
    endtask

    task automatic t_round_trip();
        logic [31:0] r;
        logic [31:0] p0 = 32'h0F1E_2D3C, p1 = 32'h4B5A_6978;
        logic [31:0] m0 = p0, m1 = p1, ms = 32'h0;
        logic [31:0] h0 = p0, h1 = p1;
        for (int i = 0; i < ROUNDS; i++) begin
            m0 = m0 + tlo(m1, ms);
            ms = ms + DELTA;
            m1 = m1 + thi(m0, ms);
        end
        op(3'b100, 32'h0, 32'h0, r);
        for (int i = 0; i < ROUNDS; i++) begin
            op(3'b000, h0, h1, r); h0 = r;
            op(3'b001, h0, h1, r); h1 = r;
        end
        chk("R10 cipher v0", h0, m0);
        chk("R10 cipher v1", h1, m1);
        op(3'b100, DELTA * 32'(ROUNDS), 32'h0, r);
        for (int i = 0; i < ROUNDS; i++) begin
            op(3'b011, h0, h1, r); h1 = r;
            op(3'b010, h0, h1, r); h0 = r;
        end
        chk("R10 plain v0", h0, p0);
        chk("R10 plain v1", h1, p1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_keys();
        t_init();
        t_steps();
        t_illegal();
        t_timing();
        t_round_trip();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule